// File: doc/BRIEF.md
# Serial-Loaded Volume Ramp with Soft Mute

This block scales a two-channel stream of signed audio samples by a gain that never jumps. Software or a neighbouring controller shifts an 11-bit attenuation word into the block over a slow three-wire port made of a data line, a bit clock and a latch strobe. The three wires are sampled by the system clock through synchroniser chains, so the port may run at any rate well below the system clock. The latched word is the gain target. Gain equals target/1024, so 1024 is unity and 0 is silence.

A separate current-gain register approaches the target by a bounded step once per input sample. A new target may arrive while a ramp is still under way. The ramp then turns toward the new value from wherever the gain stands. A mute request overrides the target with zero, so the gain fades out over 512 sample periods. Releasing mute fades the gain back to the stored target at the same rate.

Every sample strobe produces one registered output pair. Each output is the input times the current gain, shifted down by ten bits and saturated. Pulling reset low clears both outputs at once, without waiting for a clock edge.

Top module: `audio_gain_ramp`

## Requirements
- R1: While `rstN` is low, `outLeft`, `outRight` and `outValid` are 0, and they fall to 0 as soon as `rstN` falls, without waiting for a clock edge.
- R2: Each rising edge of `serClk`, as seen after synchronisation, shifts `serData` into an 11-bit register at the LSB end. A word is therefore sent MSB first, 11 bits per word.
- R3: A rising edge of `serLatch` loads the shift register into the gain target. A loaded value above 1024 is clamped to 1024. Edges of `serClk` with no latch edge leave the target unchanged.
- R4: After reset both the target and the current gain are 1024, so every output equals its input.
- R5: On every `sampleStrobe` the current gain moves toward the goal by 2, or by the remaining distance when that is smaller. It never passes the goal. Without a strobe the gain holds.
- R6: A target loaded during a ramp redirects the ramp from the present gain value, with no restart.
- R7: While `muteReq` is high the goal is 0 for both channels, so a gain of 1024 reaches 0 after 512 strobes and then stays at 0. After `muteReq` falls the gain ramps back to the stored target. Targets loaded during mute are kept for that return.
- R8: One cycle after a strobe, `outValid` is 1, and each output equals floor(input × gain / 1024), saturated to the signed `SAMPLE_W` range. The gain used is the value held before that strobe's step, and both channels use the same gain. `outValid` is 0 in the cycle after any cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, asynchronous assertion |
| serData | input | 1 | Serial attenuation data, MSB first |
| serClk | input | 1 | Serial bit clock, data taken on its rising edge |
| serLatch | input | 1 | Latch strobe, rising edge loads the target |
| muteReq | input | 1 | High requests a soft fade to silence |
| sampleStrobe | input | 1 | One-cycle pulse per input sample pair |
| inLeft | input | SAMPLE_W | Left input sample, two's complement |
| inRight | input | SAMPLE_W | Right input sample, two's complement |
| outLeft | output | SAMPLE_W | Scaled left sample |
| outRight | output | SAMPLE_W | Scaled right sample |
| outValid | output | 1 | High for one cycle when a scaled pair is ready |

## Verification
A scaled pair is due exactly one clock after its `sampleStrobe`, and it is computed with the gain held before that strobe's step. A serial wire's change reaches the edge detectors two clocks after it is driven, and a latch edge changes the target on the third clock. The new target therefore first affects the gain at the next strobe after that. The bench drives all inputs on the falling edge and advances its behavioural model on the rising edge. It compares every output on the following falling edge, so each of these latencies falls naturally into the cycle being checked. The asynchronous clear is checked one nanosecond after reset falls in mid-cycle.

// File: rtl/gain_ramp_pkg.sv
package gain_ramp_pkg;
  // width of the attenuation word and of the gain register
  localparam int GAIN_W = 11;
  // gain value that means unity (1024 for an 11-bit word)
  localparam int UNITY  = 1 << (GAIN_W - 1);

  // control-to-datapath strobes
  typedef struct packed {
    logic              sampleTick;  // advance the ramp and scale one sample pair
    logic [GAIN_W-1:0] goal;        // value the ramp is heading for
  } rampCmd_t;
endpackage

// File: rtl/gain_ramp_ctrl.sv
module gain_ramp_ctrl
  import gain_ramp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     serData,
  input  logic     serClk,
  input  logic     serLatch,
  input  logic     muteReq,
  input  logic     sampleStrobe,
  output rampCmd_t cmd
);
  localparam int N_WIRES = 3;
  localparam logic [GAIN_W-1:0] UNITY_V = GAIN_W'(UNITY);

  logic [N_WIRES-1:0] rawWires;
  logic [N_WIRES-1:0][SYNC_STAGES-1:0] syncChain;
  logic clkSync, latchSync, dataSync;
  logic clkPrev, latchPrev;
  logic bitRise, latchRise;
  logic [GAIN_W-1:0] shiftReg;
  logic [GAIN_W-1:0] targetQ;

  assign rawWires = {serData, serLatch, serClk};

  for (genvar w = 0; w < N_WIRES; w++) begin : gSync
    if (SYNC_STAGES == 1) begin : gOne
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[w] <= '0;
        else       syncChain[w] <= rawWires[w];
      end
    end else begin : gMany
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[w] <= '0;
        else       syncChain[w] <= {syncChain[w][SYNC_STAGES-2:0], rawWires[w]};
      end
    end
  end

  assign clkSync   = syncChain[0][SYNC_STAGES-1];
  assign latchSync = syncChain[1][SYNC_STAGES-1];
  assign dataSync  = syncChain[2][SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev   <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      clkPrev   <= clkSync;
      latchPrev <= latchSync;
    end
  end

  assign bitRise   = clkSync & ~clkPrev;
  assign latchRise = latchSync & ~latchPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        shiftReg <= '0;
    else if (bitRise) shiftReg <= {shiftReg[GAIN_W-2:0], dataSync};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          targetQ <= UNITY_V;
    else if (latchRise) targetQ <= (shiftReg > UNITY_V) ? UNITY_V : shiftReg;
  end

  always_comb begin
    cmd.sampleTick = sampleStrobe;
    cmd.goal       = muteReq ? '0 : targetQ;
  end

  // R3: the target never exceeds unity
  assert_target_clamp_R3: assert property (@(posedge clk) disable iff (!rstN)
    targetQ <= UNITY_V);

  // R3: without a latch edge the target holds
  assert_target_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !latchRise |=> $stable(targetQ));

  // R2: the shift register moves only on a bit-clock edge
  assert_shift_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !bitRise |=> $stable(shiftReg));
endmodule

// File: rtl/gain_ramp_dp.sv
module gain_ramp_dp
  import gain_ramp_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int STEP     = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  rampCmd_t            cmd,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight,
  output logic                outValid
);
  localparam int N_CH   = 2;
  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
  localparam int SHIFT  = GAIN_W - 1;
  localparam logic [GAIN_W-1:0] UNITY_V = GAIN_W'(UNITY);
  localparam logic [GAIN_W-1:0] STEP_V  = GAIN_W'(STEP);
  localparam logic signed [PROD_W-1:0] SAT_HI =
    $signed({{(PROD_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}});
  localparam logic signed [PROD_W-1:0] SAT_LO =
    $signed({{(PROD_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}});

  logic [GAIN_W-1:0] gainQ, gainD, gap;
  logic [N_CH-1:0][SAMPLE_W-1:0] chIn, chOut;

  always_comb begin
    gap   = '0;
    gainD = gainQ;
    if (gainQ < cmd.goal) begin
      gap   = cmd.goal - gainQ;
      gainD = gainQ + ((gap > STEP_V) ? STEP_V : gap);
    end else if (gainQ > cmd.goal) begin
      gap   = gainQ - cmd.goal;
      gainD = gainQ - ((gap > STEP_V) ? STEP_V : gap);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               gainQ <= UNITY_V;
    else if (cmd.sampleTick) gainQ <= gainD;
  end

  assign chIn = {inRight, inLeft};

  for (genvar ch = 0; ch < N_CH; ch++) begin : gChan
    logic signed [PROD_W-1:0] sampleExt, gainExt, prod, scaled;
    logic [SAMPLE_W-1:0] satVal;

    assign sampleExt = PROD_W'($signed(chIn[ch]));
    assign gainExt   = $signed(PROD_W'(gainQ));
    assign prod      = sampleExt * gainExt;
    assign scaled    = prod >>> SHIFT;

    always_comb begin
      if (scaled > SAT_HI)      satVal = SAT_HI[SAMPLE_W-1:0];
      else if (scaled < SAT_LO) satVal = SAT_LO[SAMPLE_W-1:0];
      else                      satVal = scaled[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               chOut[ch] <= '0;
      else if (cmd.sampleTick) chOut[ch] <= satVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= cmd.sampleTick;
  end

  assign outLeft  = chOut[0];
  assign outRight = chOut[1];

  // R5: gain stays within zero..unity
  assert_gain_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    gainQ <= UNITY_V);

  // R5: a strobe moves the gain by at most one step
  assert_step_size_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.sampleTick |=> ((gainQ >= $past(gainQ)) ? (gainQ - $past(gainQ))
                                                : ($past(gainQ) - gainQ)) <= STEP_V);

  // R5: no strobe, no movement
  assert_gain_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.sampleTick |=> $stable(gainQ));

  // R5: rising ramp never overshoots its goal
  assert_no_overshoot_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.sampleTick && gainQ <= cmd.goal) |=> gainQ <= $past(cmd.goal));

  // R7: once silent under a zero goal, the gain stays silent
  assert_mute_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.goal == '0 && gainQ == '0) |=> gainQ == '0);

  // R8: a pair is flagged exactly one cycle after each strobe
  assert_valid_timing_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.sampleTick |=> outValid);
  assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.sampleTick |=> !outValid);
endmodule

// File: rtl/audio_gain_ramp.sv
module audio_gain_ramp
  import gain_ramp_pkg::*;
#(
  parameter int SAMPLE_W    = 20,
  parameter int STEP        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serData,
  input  logic                serClk,
  input  logic                serLatch,
  input  logic                muteReq,
  input  logic                sampleStrobe,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight,
  output logic                outValid
);
  rampCmd_t cmd;

  gain_ramp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk),
    .serLatch(serLatch), .muteReq(muteReq), .sampleStrobe(sampleStrobe),
    .cmd(cmd)
  );

  gain_ramp_dp #(.SAMPLE_W(SAMPLE_W), .STEP(STEP)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .inLeft(inLeft), .inRight(inRight),
    .outLeft(outLeft), .outRight(outRight), .outValid(outValid)
  );
endmodule

// File: tb/sim_audio_gain_ramp.sv
module sim_audio_gain_ramp;
  localparam int SW = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serData = 1'b0, serClk = 1'b0, serLatch = 1'b0, muteReq = 1'b0;
  logic sampleStrobe = 1'b0;
  logic [SW-1:0] inLeft = '0, inRight = '0;
  logic [SW-1:0] outLeft, outRight;
  logic outValid;

  int errors = 0;
  int checks = 0;
  string phaseTag = "R1";
  bit finished = 0;

  audio_gain_ramp u0 (
    .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk),
    .serLatch(serLatch), .muteReq(muteReq), .sampleStrobe(sampleStrobe),
    .inLeft(inLeft), .inRight(inRight), .outLeft(outLeft),
    .outRight(outRight), .outValid(outValid)
  );

  always #5 clk = ~clk;

  // ---------------- behavioural reference ----------------
  bit m_s1c, m_s2c, m_pc, m_s1l, m_s2l, m_pl, m_s1d, m_s2d;
  int m_shift, m_target, m_gain, m_outL, m_outR;
  bit m_valid;

  function automatic int scaleRef(int x, int g);
    longint p = longint'(x) * longint'(g);
    p = p >>> 10;
    if (p > 524287)  p = 524287;
    if (p < -524288) p = -524288;
    return int'(p);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {m_s1c, m_s2c, m_pc, m_s1l, m_s2l, m_pl, m_s1d, m_s2d} = '0;
      m_shift = 0; m_target = 1024; m_gain = 1024;
      m_outL = 0; m_outR = 0; m_valid = 0;
    end else begin
      bit clkEdge, latEdge;
      int goal;
      clkEdge = m_s2c && !m_pc;
      latEdge = m_s2l && !m_pl;
      goal = muteReq ? 0 : m_target;
      if (sampleStrobe) begin
        m_outL = scaleRef(int'($signed(inLeft)), m_gain);
        m_outR = scaleRef(int'($signed(inRight)), m_gain);
        m_valid = 1;
        if (m_gain < goal) m_gain += ((goal - m_gain) > 2) ? 2 : (goal - m_gain);
        else if (m_gain > goal) m_gain -= ((m_gain - goal) > 2) ? 2 : (m_gain - goal);
      end else m_valid = 0;
      if (latEdge) m_target = (m_shift > 1024) ? 1024 : m_shift;
      if (clkEdge) m_shift = ((m_shift << 1) | int'(m_s2d)) & 11'h7FF;
      m_pc = m_s2c; m_s2c = m_s1c; m_s1c = serClk;
      m_pl = m_s2l; m_s2l = m_s1l; m_s1l = serLatch;
      m_s2d = m_s1d; m_s1d = serData;
    end
  end

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      if (!rstN) begin
        checkVal("R1 left", int'($signed(outLeft)), 0);
        checkVal("R1 valid", int'(outValid), 0);
      end else begin
        checkVal({phaseTag, " left"}, int'($signed(outLeft)), m_outL);
        checkVal({phaseTag, " right"}, int'($signed(outRight)), m_outR);
        checkVal({phaseTag, " valid"}, int'(outValid), int'(m_valid));
      end
    end
  end

  // ---------------- sample stream ----------------
  int strobeCnt = 0;
  int seed = 7;
  int sampleNum = 0;
  always @(negedge clk) begin
    strobeCnt = (strobeCnt + 1) % 4;
    sampleStrobe <= (strobeCnt == 3);
    if (strobeCnt == 3) begin
      sampleNum++;
      seed = seed * 1103515245 + 12345;
      if (sampleNum % 16 == 0) begin
        inLeft  <= 20'h80000;
        inRight <= 20'h7FFFF;
      end else begin
        inLeft  <= seed[19:0];
        inRight <= seed[29:10];
      end
    end
  end

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendWord(int value, bit doLatch);
    for (int b = 10; b >= 0; b--) begin
      @(negedge clk);
      serData = value[b];
      serClk  = 1'b0;
      waitCycles(3);
      serClk = 1'b1;
      waitCycles(3);
    end
    serClk = 1'b0;
    waitCycles(3);
    if (doLatch) begin
      serLatch = 1'b1;
      waitCycles(3);
      serLatch = 1'b0;
      waitCycles(3);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    phaseTag = "R1";
    waitCycles(5);
    checkVal("R1 reset right", int'($signed(outRight)), 0);
    @(negedge clk);
    rstN = 1'b1;
    phaseTag = "R4";
    waitCycles(60);
    phaseTag = "R3";          // R2 shifting + R3 latch, down ramp under R5
    sendWord(300, 1'b1);
    phaseTag = "R5";
    waitCycles(1600);
    phaseTag = "R6";          // retarget mid-ramp, odd goal checks no overshoot
    sendWord(900, 1'b1);
    waitCycles(120);
    sendWord(401, 1'b1);
    waitCycles(2200);
    phaseTag = "R3";          // oversized word clamps to unity
    sendWord(2047, 1'b1);
    waitCycles(2000);
    phaseTag = "R7";
    muteReq = 1'b1;
    waitCycles(1000);
    sendWord(512, 1'b1);      // stored for the return from mute
    waitCycles(1200);
    @(negedge clk);
    if (inLeft != '0) checkVal("R7 muted left", int'($signed(outLeft)), 0);
    checkVal("R7 muted right", int'($signed(outRight)), 0);
    muteReq = 1'b0;
    waitCycles(2200);
    phaseTag = "R2";          // bit clocks without latch leave the gain alone
    sendWord(17, 1'b0);
    waitCycles(200);
    phaseTag = "R8";
    waitCycles(100);
    @(negedge clk);
    #2 rstN = 1'b0;
    #1;
    checkVal("R1 async left", int'($signed(outLeft)), 0);
    checkVal("R1 async right", int'($signed(outRight)), 0);
    checkVal("R1 async valid", int'(outValid), 0);
    waitCycles(4);
    @(negedge clk);
    rstN = 1'b1;
    phaseTag = "R4";
    waitCycles(80);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule